// File: doc/BRIEF.md
# Coprocessor Word-Transfer Address Sequencer

This block produces the memory addresses for a coprocessor load or store that moves one or more consecutive words. A request gives a base register value with its register index, the address of the current instruction, an 8-bit word offset, three addressing-mode bits and a word count. The block first works out the effective base. It scales the offset to bytes and applies it to form a modified base. It then issues one address per beat and steps by one word each time the memory side accepts a beat.

When the transfer ends, the block raises a one-cycle done pulse. The transfer ends after the last accepted beat, or early when the memory side reports an abort. If write-back was requested, the block presents the modified base as the new register value in that same cycle, even after an abort, so the instruction can be re-issued from a consistent state.

A request that names the program-counter register as the base and also asks for write-back is rejected. The block raises a one-cycle illegal flag, issues no beats and makes no write-back.

Top module: `cp_xfer_agen`

## Requirements
- R1: After reset, `busy`, `beatValid`, `done`, `wbValid` and `illegal` are all low.
- R2: The modified base is the effective base plus `offImm`×4 when `upDir`=1, and minus `offImm`×4 when `upDir`=0. All arithmetic is modulo 2^32.
- R3: When `preIdx`=1 the first beat address is the modified base. When `preIdx`=0 it is the unmodified effective base.
- R4: Each beat after the first has an address exactly 4 above the previous beat. The address moves only after a cycle with `memAck` high. It holds steady while neither `memAck` nor `memAbort` is high.
- R5: A request issues `wordCount` beats, and a count of 0 is treated as 1. `done` is high for exactly one cycle, the cycle after the final beat is accepted, and `beatValid` is low in that cycle.
- R6: `wbValid` is high together with `done` only when `wbReq`=1. `wbData` then equals the modified base for both `preIdx` values. With `wbReq`=0, `wbValid` stays low.
- R7: When `baseIdx` is 15, the effective base is `instrAddr`+8 and `baseVal` is ignored.
- R8: A request with `baseIdx`=15 and `wbReq`=1 raises `illegal` for one cycle, the cycle after `startValid`. No beat, no `done` and no `wbValid` follow.
- R9: `memAbort` on an issued beat ends the transfer. `done` pulses in the next cycle, together with `wbValid` and the modified base when `wbReq`=1. No further beats follow.
- R10: The two least significant bits of the effective base pass into every beat address unchanged.
- R11: `startValid` is ignored while `busy` is high. The current beat address is unchanged and `illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request strobe, taken only when idle |
| baseVal | input | 32 | Base register value |
| baseIdx | input | 4 | Base register index (15 selects the program counter) |
| instrAddr | input | 32 | Address of the current instruction |
| offImm | input | 8 | Unsigned word offset |
| preIdx | input | 1 | 1: apply the offset before the first beat |
| upDir | input | 1 | 1: add the offset, 0: subtract it |
| wbReq | input | 1 | 1: write the modified base back |
| wordCount | input | 5 | Number of words (0 acts as 1) |
| memAck | input | 1 | Memory accepts the current beat |
| memAbort | input | 1 | Memory aborts the current beat |
| busy | output | 1 | Transfer in progress |
| beatValid | output | 1 | A beat address is presented |
| beatAddr | output | 32 | Current beat address |
| done | output | 1 | One-cycle end-of-transfer pulse |
| wbValid | output | 1 | Write-back of the new base |
| wbData | output | 32 | New base value |
| illegal | output | 1 | One-cycle illegal-encoding pulse |

## Verification
The bench sweeps all eight combinations of the pre-index, direction and write-back bits. Each combination runs against offsets of 0, 1, mid-range and maximum, with an ordinary base register and with the program-counter base, and with word counts from zero to three. Bases with both low bits set and bases near the top of the address space separate add from subtract and pre-index from post-index, and show that the low bits are kept and that the address wraps. Stall cycles with a competing request on the inputs show that the address holds and that new requests are ignored while busy. Aborts on the first and middle beats show that the transfer ends early while the write-back still happens.

// File: rtl/cp_xfer_agen_pkg.sv
package cp_xfer_agen_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic selPc;    // base comes from instruction address
    logic advance;  // step to next word
  } agenStrb_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } agenState_t;
endpackage

// File: rtl/cp_xfer_agen_ctrl.sv
module cp_xfer_agen_ctrl
  import cp_xfer_agen_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int CNT_W  = 5,
  parameter int PC_REG = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [REG_W-1:0] baseIdx,
  input  logic             wbReq,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             memAck,
  input  logic             memAbort,
  output agenStrb_t        strb,
  output logic             busy,
  output logic             beatValid,
  output logic             done,
  output logic             wbValid,
  output logic             illegal
);
  localparam logic [REG_W-1:0] PC_IDX = REG_W'(PC_REG);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  agenState_t state;
  logic [CNT_W-1:0] remain;
  logic wbBitQ, doneQ, wbValidQ, illegalQ;

  logic startOk, isPcBase, badReq, beatEnd, lastBeat, finish;

  always_comb begin
    startOk  = startValid && (state == ST_IDLE);
    isPcBase = (baseIdx == PC_IDX);
    badReq   = startOk && isPcBase && wbReq;
    beatEnd  = (state == ST_RUN) && (memAck || memAbort);
    lastBeat = (remain == ONE);
    finish   = beatEnd && (memAbort || lastBeat);
    strb.load    = startOk && !badReq;
    strb.selPc   = isPcBase;
    strb.advance = beatEnd && !finish;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      remain   <= '0;
      wbBitQ   <= 1'b0;
      doneQ    <= 1'b0;
      wbValidQ <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      doneQ    <= finish;
      wbValidQ <= finish && wbBitQ;
      illegalQ <= badReq;
      if (strb.load) begin
        state  <= ST_RUN;
        remain <= (wordCount == '0) ? ONE : wordCount;
        wbBitQ <= wbReq;
      end else if (finish) begin
        state  <= ST_IDLE;
      end else if (strb.advance) begin
        remain <= remain - ONE;
      end
    end
  end

  assign busy      = (state == ST_RUN);
  assign beatValid = (state == ST_RUN);
  assign done      = doneQ;
  assign wbValid   = wbValidQ;
  assign illegal   = illegalQ;

  // R9
  abort_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && memAbort |=> done && !beatValid);

  // R6
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done);

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !beatValid && !done && !wbValid);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && startValid |=> !illegal);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/cp_xfer_agen_dp.sv
module cp_xfer_agen_dp
  import cp_xfer_agen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 8,
  parameter int PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  agenStrb_t         strb,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [OFF_W-1:0]  offImm,
  input  logic              preIdx,
  input  logic              upDir,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] newBase
);
  localparam int WORD_SHIFT = 2;
  localparam int STEP       = 1 << WORD_SHIFT;
  localparam int PAD_W      = ADDR_W - OFF_W - WORD_SHIFT;

  logic [ADDR_W-1:0] effBase, offBytes, modBase, firstAddr;

  always_comb begin
    effBase   = strb.selPc ? (instrAddr + ADDR_W'(PC_AHEAD)) : baseVal;
    offBytes  = {{PAD_W{1'b0}}, offImm, {WORD_SHIFT{1'b0}}};
    modBase   = upDir ? (effBase + offBytes) : (effBase - offBytes);
    firstAddr = preIdx ? modBase : effBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      newBase <= '0;
    end else if (strb.load) begin
      curAddr <= firstAddr;
      newBase <= modBase;
    end else if (strb.advance) begin
      curAddr <= curAddr + ADDR_W'(STEP);
    end
  end

  // R10
  low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> curAddr[WORD_SHIFT-1:0] == $past(curAddr[WORD_SHIFT-1:0]));
endmodule

// File: rtl/cp_xfer_agen.sv
module cp_xfer_agen
  import cp_xfer_agen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 8,
  parameter int REG_W    = 4,
  parameter int CNT_W    = 5,
  parameter int PC_REG   = 15,
  parameter int PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [REG_W-1:0]  baseIdx,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [OFF_W-1:0]  offImm,
  input  logic              preIdx,
  input  logic              upDir,
  input  logic              wbReq,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              memAck,
  input  logic              memAbort,
  output logic              busy,
  output logic              beatValid,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              done,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbData,
  output logic              illegal
);
  agenStrb_t strb;

  cp_xfer_agen_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W), .PC_REG(PC_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .baseIdx(baseIdx),
    .wbReq(wbReq), .wordCount(wordCount), .memAck(memAck), .memAbort(memAbort),
    .strb(strb), .busy(busy), .beatValid(beatValid), .done(done),
    .wbValid(wbValid), .illegal(illegal)
  );

  cp_xfer_agen_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .PC_AHEAD(PC_AHEAD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .baseVal(baseVal),
    .instrAddr(instrAddr), .offImm(offImm), .preIdx(preIdx), .upDir(upDir),
    .curAddr(beatAddr), .newBase(wbData)
  );

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !memAck && !memAbort |=> beatValid && $stable(beatAddr));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && memAck && !memAbort |=>
      !beatValid || (beatAddr == $past(beatAddr) + ADDR_W'(4)));
endmodule

// File: tb/cp_xfer_agen_bench.sv
module cp_xfer_agen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [31:0] baseVal = '0, instrAddr = '0;
  logic [3:0] baseIdx = '0;
  logic [7:0] offImm = '0;
  logic preIdx = 1'b0, upDir = 1'b0, wbReq = 1'b0;
  logic [4:0] wordCount = '0;
  logic memAck = 1'b0, memAbort = 1'b0;
  logic busy, beatValid, done, wbValid, illegal;
  logic [31:0] beatAddr, wbData;

  int checks = 0;
  int failures = 0;
  int stallSeed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_xfer_agen u_cp_xfer_agen (
    .clk(clk), .rstN(rstN), .startValid(startValid), .baseVal(baseVal),
    .baseIdx(baseIdx), .instrAddr(instrAddr), .offImm(offImm), .preIdx(preIdx),
    .upDir(upDir), .wbReq(wbReq), .wordCount(wordCount), .memAck(memAck),
    .memAbort(memAbort), .busy(busy), .beatValid(beatValid), .beatAddr(beatAddr),
    .done(done), .wbValid(wbValid), .wbData(wbData), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doXfer(input logic [31:0] b, input logic [3:0] idx, input logic [31:0] pc,
                        input logic [7:0] off, input logic p, input logic u, input logic w,
                        input int cnt, input int abortAt);
    logic [31:0] eff, mod, expAddr;
    int n;
    bit stopped;
    eff = (idx == 4'd15) ? pc + 32'd8 : b;
    mod = u ? eff + {22'd0, off, 2'b00} : eff - {22'd0, off, 2'b00};
    expAddr = p ? mod : eff;
    n = (cnt == 0) ? 1 : cnt;
    @(negedge clk);
    startValid = 1'b1; baseVal = b; baseIdx = idx; instrAddr = pc; offImm = off;
    preIdx = p; upDir = u; wbReq = w; wordCount = 5'(cnt);
    @(negedge clk);
    startValid = 1'b0;
    if (idx == 4'd15 && w) begin
      chk("R8 illegal pulse", {31'd0, illegal}, 32'd1);
      chk("R8 no beat", {31'd0, beatValid}, 32'd0);
      @(negedge clk);
      chk("R8 illegal one cycle", {31'd0, illegal}, 32'd0);
      chk("R8 no done/wb", {30'd0, done, wbValid}, 32'd0);
      return;
    end
    chk("R8 legal no flag", {31'd0, illegal}, 32'd0);
    stopped = 0;
    for (int k = 0; k < n && !stopped; k++) begin
      if (((k + stallSeed) % 3) == 1) begin
        chk("R4 beat valid stall", {31'd0, beatValid}, 32'd1);
        chk("R3 R4 addr before stall", beatAddr, expAddr);
        startValid = 1'b1; baseVal = 32'h5A5A5A5A; baseIdx = 4'd15; wbReq = 1'b1;
        @(negedge clk);
        startValid = 1'b0; baseVal = b; baseIdx = idx; wbReq = w;
        chk("R11 addr held busy", beatAddr, expAddr);
        chk("R11 no illegal busy", {31'd0, illegal}, 32'd0);
      end
      chk("R5 beat valid", {31'd0, beatValid}, 32'd1);
      chk("R2 R3 R4 R10 beat addr", beatAddr, expAddr);
      if (k == abortAt) memAbort = 1'b1; else memAck = 1'b1;
      @(negedge clk);
      memAck = 1'b0; memAbort = 1'b0;
      if (k == abortAt || k == n - 1) begin
        stopped = 1;
        chk(k == abortAt ? "R9 done after abort" : "R5 done", {31'd0, done}, 32'd1);
        chk("R5 R9 beat ends", {31'd0, beatValid}, 32'd0);
        chk("R6 wb valid", {31'd0, wbValid}, {31'd0, w});
        if (w) chk("R6 R7 wb data", wbData, mod);
      end else begin
        chk("R5 no early done", {31'd0, done}, 32'd0);
      end
      expAddr = expAddr + 32'd4;
    end
    @(negedge clk);
    chk("R5 done one cycle", {30'd0, done, wbValid}, 32'd0);
    stallSeed++;
  endtask

  initial begin
    logic [31:0] bases [3];
    logic [7:0] offs [4];
    bases[0] = 32'h0000_0013; bases[1] = 32'hFFFF_FF07; bases[2] = 32'h8000_0002;
    offs[0] = 8'h00; offs[1] = 8'h01; offs[2] = 8'h80; offs[3] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, busy, beatValid, done, wbValid, illegal}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {27'd0, busy, beatValid, done, wbValid, illegal}, 32'd0);
    for (int m = 0; m < 8; m++)
      for (int oi = 0; oi < 4; oi++)
        for (int bi = 0; bi < 3; bi++)
          for (int pcb = 0; pcb < 2; pcb++)
            doXfer(bases[bi], pcb ? 4'd15 : 4'd3, 32'hFFFF_FFFC - 32'(bi * 16),
                   offs[oi], m[2], m[1], m[0], (oi + bi + m) % 4, -1);
    // R7: baseVal ignored with index 15
    doXfer(32'hDEAD_BEEF, 4'd15, 32'h0000_1000, 8'h02, 1'b1, 1'b1, 1'b0, 2, -1);
    // R9: abort on first and middle beats
    doXfer(32'h0000_2001, 4'd4, 32'h0, 8'h10, 1'b1, 1'b0, 1'b1, 3, 0);
    doXfer(32'h0000_3002, 4'd5, 32'h0, 8'h10, 1'b0, 1'b1, 1'b1, 4, 1);
    doXfer(32'h0000_4003, 4'd6, 32'h0, 8'h10, 1'b0, 1'b1, 1'b0, 4, 2);
    // R5: longer transfer
    doXfer(32'h0000_5000, 4'd7, 32'h0, 8'h04, 1'b1, 1'b1, 1'b1, 31, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule